// File: doc/BRIEF.md
# Shared-Exponent Mantissa Slicer

This block converts a short vector of double-precision values, such as one row or one column of a matrix, into block fixed-point form. The elements arrive one per transfer and are kept in a small local buffer. While they are stored, a running maximum picks out the largest biased exponent among the nonzero elements, and this becomes the shared power-of-two scale for the whole vector.

In the second pass, each stored element is shifted right to align with that shared scale. Its sign is applied in two's complement, and the result is cut into `NUM_SLICES` bytes, most significant byte first. The top byte is a signed integer and every lower byte is an unsigned digit. Each output transfer carries all slices of one element, the shared exponent, and a flag that marks the final element of the vector.

Both streams use a valid/ready handshake. A transfer takes place on a rising clock edge when valid and ready are both high. The input side is ready only while the buffer is loading. The output side presents an element and holds it, unchanged, until the consumer takes it, so the consumer may stall for as long as it needs to. The buffer accepts no new input until the final element of the current vector has been taken.

Top module: `shexp_slicer`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `out_valid` is 0 and `in_ready` is 1.
- R2: The block accepts exactly `VEC_LEN` input elements and then holds `in_ready` low until the output transfer that carries `out_last` completes. `in_ready` and `out_valid` are never high together.
- R3: `out_exp` is the largest 11-bit biased exponent field (bits 62..52) among the elements of the vector whose field is nonzero. It is 0 for a vector whose elements all have a zero exponent field, and it stays constant across all outputs of one vector.
- R4: Let F = 8·`NUM_SLICES`, e be the element's exponent field and d = `out_exp` − e. The magnitude is floor(({1, bits 51..0}) / 2^(53−(F−1)+d)). Bit 63 of the element is the sign. `out_slices` equals the magnitude as an F-bit value, negated in two's complement when the sign is set.
- R5: Slice k occupies `out_slices` bits [F−1−8k −: 8], with slice 0 the most significant. For a negative element whose magnitude is nonzero, bit F−1 (the sign of the signed top slice) is 1.
- R6: An element whose exponent field is 0 (a zero or a denormal, with either sign) produces all-zero slices and has no effect on `out_exp`.
- R7: Elements leave in the order they arrived. `out_last` is 1 only on the `VEC_LEN`-th output of a vector.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_slices`, `out_exp` and `out_last` hold their values into the next cycle.
- R9: A nonzero element whose exponent is F−1 or more below `out_exp` is truncated to all-zero slices.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input element present |
| in_ready | output | 1 | Block accepts an input element |
| in_data | input | 64 | Binary64 element |
| out_valid | output | 1 | Sliced element present |
| out_ready | input | 1 | Consumer takes the sliced element |
| out_slices | output | 8·NUM_SLICES | Slices of one element, slice 0 in the top byte |
| out_exp | output | 11 | Shared biased exponent of the vector |
| out_last | output | 1 | Marks the final element of the vector |

## Verification
The assertions assume that the consumer's `out_ready` and the producer's `in_valid` are plain booleans that may change in any cycle. They also assume that the input carries no NaN or infinity patterns, because exponent field 2047 would be taken as an ordinary large exponent. The stimulus builds exponents from a per-vector base between 900 and 1100, minus a small random offset, so the field never reaches 2047. Zeros and denormals are mixed in on purpose. Random gaps on the input and random stalls on the output exercise every handshake state.

// File: rtl/shexp_slicer_pkg.sv
package shexp_slicer_pkg;
  localparam int FP_W   = 64;
  localparam int EXP_W  = 11;
  localparam int FRAC_W = 52;
  localparam int SIG_W  = FRAC_W + 1;

  typedef logic [EXP_W-1:0] exp_t;
  typedef logic [FP_W-1:0]  fp_t;

  typedef enum logic {ST_LOAD, ST_EMIT} phase_e;

  function automatic exp_t exp_field(fp_t x);
    return x[FP_W-2 -: EXP_W];
  endfunction
endpackage

// File: rtl/shexp_exp_max.sv
module shexp_exp_max
  import shexp_slicer_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic upd,
  input  exp_t exp_in,
  output exp_t exp_max
);
  // A zero field marks a flushed zero and never wins the maximum.
  logic take;
  assign take = upd && (exp_in != '0) && (exp_in > exp_max);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     exp_max <= '0;
    else if (clr)   exp_max <= '0;
    else if (take)  exp_max <= exp_in;
  end
endmodule

// File: rtl/shexp_vec_buf.sv
module shexp_vec_buf #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 64,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (wr_en && (wr_idx == IDX_W'(g))) mem[g] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rd_idx == IDX_W'(i)) rd_data = mem[i];
    end
  end
endmodule

// File: rtl/shexp_align.sv
module shexp_align
  import shexp_slicer_pkg::*;
#(
  parameter int NUM_SLICES = 3,
  parameter int SLICE_W    = 8
) (
  input  fp_t                            elem,
  input  exp_t                           shared_exp,
  output logic [NUM_SLICES*SLICE_W-1:0]  slices
);
  localparam int FIX_W  = NUM_SLICES * SLICE_W;
  localparam int MAG_W  = FIX_W - 1;
  localparam int WIDE_W = SIG_W + MAG_W;

  exp_t               e;
  logic               neg;
  logic [SIG_W-1:0]   sig;
  logic [EXP_W:0]     gap;
  logic [EXP_W+1:0]   sh;
  logic [WIDE_W-1:0]  wide;
  logic [WIDE_W-1:0]  shifted;
  logic [MAG_W-1:0]   mag;
  logic [FIX_W-1:0]   fixed_pt;

  always_comb begin
    e        = exp_field(elem);
    neg      = elem[FP_W-1];
    sig      = {1'b1, elem[FRAC_W-1:0]};
    gap      = {1'b0, shared_exp} - {1'b0, e};
    wide     = {sig, {MAG_W{1'b0}}};
    sh       = {1'b0, gap} + (EXP_W+2)'(SIG_W);
    shifted  = '0;
    mag      = '0;
    // Flushed zeros and elements shifted fully out give an empty magnitude.
    if ((e != '0) && (gap < (EXP_W+1)'(MAG_W))) begin
      shifted = wide >> sh;
      mag     = shifted[MAG_W-1:0];
    end
    fixed_pt = neg ? (FIX_W'(0) - {1'b0, mag}) : {1'b0, mag};
  end

  for (genvar k = 0; k < NUM_SLICES; k++) begin : g_slice
    assign slices[FIX_W-1-k*SLICE_W -: SLICE_W] = fixed_pt[FIX_W-1-k*SLICE_W -: SLICE_W];
  end
endmodule

// File: rtl/shexp_slicer.sv
module shexp_slicer
  import shexp_slicer_pkg::*;
#(
  parameter int VEC_LEN    = 8,
  parameter int NUM_SLICES = 3,
  parameter int SLICE_W    = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           in_valid,
  output logic                           in_ready,
  input  logic [63:0]                    in_data,
  output logic                           out_valid,
  input  logic                           out_ready,
  output logic [NUM_SLICES*SLICE_W-1:0]  out_slices,
  output logic [10:0]                    out_exp,
  output logic                           out_last
);
  localparam int IDX_W = (VEC_LEN > 1) ? $clog2(VEC_LEN) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(VEC_LEN - 1);

  phase_e            phase;
  logic [IDX_W-1:0]  idx;
  logic              in_fire;
  logic              out_fire;
  fp_t               rd_elem;
  exp_t              shared;

  assign in_ready  = (phase == ST_LOAD);
  assign out_valid = (phase == ST_EMIT);
  assign in_fire   = in_valid && in_ready;
  assign out_fire  = out_valid && out_ready;
  assign out_last  = out_valid && (idx == LAST_IDX);
  assign out_exp   = shared;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= ST_LOAD;
      idx   <= '0;
    end else begin
      unique case (phase)
        ST_LOAD: if (in_fire) begin
          if (idx == LAST_IDX) begin
            phase <= ST_EMIT;
            idx   <= '0;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        ST_EMIT: if (out_fire) begin
          if (idx == LAST_IDX) begin
            phase <= ST_LOAD;
            idx   <= '0;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        default: phase <= ST_LOAD;
      endcase
    end
  end

  shexp_vec_buf #(
    .DEPTH  (VEC_LEN),
    .DATA_W (FP_W),
    .IDX_W  (IDX_W)
  ) buf_i (
    .clk     (clk),
    .wr_en   (in_fire),
    .wr_idx  (idx),
    .wr_data (in_data),
    .rd_idx  (idx),
    .rd_data (rd_elem)
  );

  shexp_exp_max max_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (out_fire && out_last),
    .upd     (in_fire),
    .exp_in  (exp_field(in_data)),
    .exp_max (shared)
  );

  shexp_align #(
    .NUM_SLICES (NUM_SLICES),
    .SLICE_W    (SLICE_W)
  ) align_i (
    .elem       (rd_elem),
    .shared_exp (shared),
    .slices     (out_slices)
  );
endmodule

// File: rtl/shexp_slicer_chk.sv
module shexp_slicer_chk #(
  parameter int VEC_LEN    = 8,
  parameter int NUM_SLICES = 3,
  parameter int SLICE_W    = 8
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           in_valid,
  input logic                           in_ready,
  input logic                           out_valid,
  input logic                           out_ready,
  input logic [NUM_SLICES*SLICE_W-1:0]  out_slices,
  input logic [10:0]                    out_exp,
  input logic                           out_last
);
  logic [15:0] icnt;
  logic [15:0] ocnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      icnt <= '0;
      ocnt <= '0;
    end else begin
      if (out_valid && out_ready && out_last) icnt <= '0;
      else if (in_valid && in_ready)          icnt <= icnt + 16'd1;
      if (out_valid && out_ready)
        ocnt <= (ocnt == 16'(VEC_LEN - 1)) ? 16'd0 : ocnt + 16'd1;
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && in_ready)); // R1

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready); // R2

  AST_ACCEPT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |-> (icnt < 16'(VEC_LEN))); // R2

  AST_EXP_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !out_last) |=> (out_valid && $stable(out_exp))); // R3

  AST_LAST_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_last == (ocnt == 16'(VEC_LEN - 1)))); // R7

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_slices)
      && $stable(out_exp) && $stable(out_last))); // R8
endmodule

bind shexp_slicer shexp_slicer_chk #(
  .VEC_LEN    (VEC_LEN),
  .NUM_SLICES (NUM_SLICES),
  .SLICE_W    (SLICE_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_slices (out_slices),
  .out_exp    (out_exp),
  .out_last   (out_last)
);

// File: tb/shexp_slicer_tb_top.sv
`timescale 1ns/1ps
module shexp_slicer_tb_top;
  localparam int N  = 8;
  localparam int S  = 3;
  localparam int SW = 8;
  localparam int FW = S * SW;
  localparam int MW = FW - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [63:0]   in_data = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [FW-1:0] out_slices;
  logic [10:0]   out_exp;
  logic          out_last;

  int  n_run = 0;
  int  n_fail = 0;
  bit  finished = 1'b0;
  logic [63:0] vec [N];

  always #2.5 clk = ~clk;

  shexp_slicer #(.VEC_LEN(N), .NUM_SLICES(S), .SLICE_W(SW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_slices(out_slices), .out_exp(out_exp), .out_last(out_last)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp_v);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp_v);
    end
  endtask

  function automatic logic [10:0] model_exp();
    logic [10:0] m;
    m = '0;
    for (int i = 0; i < N; i++)
      if (vec[i][62:52] != 0 && vec[i][62:52] > m) m = vec[i][62:52];
    return m;
  endfunction

  function automatic logic [FW-1:0] model_slices(logic [63:0] x, logic [10:0] em);
    int          e;
    int          d;
    logic [52:0] m;
    logic [FW-1:0] mag;
    e = int'(x[62:52]);
    if (e == 0) return '0;
    d = int'(em) - e;
    if (d >= MW) return '0;
    m   = {1'b1, x[51:0]};
    mag = FW'(m >> (53 - MW + d));
    return x[63] ? (FW'(0) - mag) : mag;
  endfunction

  function automatic logic [63:0] rnd_elem(int base);
    int r;
    int e;
    logic [63:0] f;
    r = int'($urandom % 16);
    f = {$urandom, $urandom};
    if (r == 0) return {f[63], 63'b0};
    if (r == 1) return {f[63], 11'd0, f[51:0] | 52'd1};
    e = base - int'($urandom % 30);
    if (r == 2) e = base - 40;
    return {f[63], 11'(e), f[51:0]};
  endfunction

  task automatic send_vec();
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      repeat (int'($urandom % 3)) @(negedge clk);
      in_valid = 1'b1;
      in_data  = vec[i];
      while (!in_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic recv_vec(input logic [10:0] em);
    int            k;
    bit            held;
    logic [FW-1:0] h_sl;
    logic [10:0]   h_ex;
    logic          h_last;
    logic [FW-1:0] want;
    k = 0;
    held = 1'b0;
    while (k < N) begin
      @(negedge clk);
      if (held) begin
        chk(out_valid && out_slices == h_sl && out_exp == h_ex && out_last == h_last,
            "R8", "stall hold", 64'(out_slices), 64'(h_sl));
        held = 1'b0;
      end
      if (!out_valid) begin
        out_ready = 1'b0;
        continue;
      end
      if (($urandom % 4) == 0) begin
        out_ready = 1'b0;
        held = 1'b1;
        h_sl = out_slices; h_ex = out_exp; h_last = out_last;
        continue;
      end
      out_ready = 1'b1;
      want = model_slices(vec[k], em);
      chk(!in_ready, "R2", "in_ready during output", 64'(in_ready), 64'd0);
      chk(out_exp == em, "R3", "shared exponent", 64'(out_exp), 64'(em));
      chk(out_slices == want, "R4", "slices", 64'(out_slices), 64'(want));
      chk(out_last == (k == N - 1), "R7", "last flag", 64'(out_last), 64'(k == N - 1));
      if (vec[k][62:52] == 0)
        chk(out_slices == '0, "R6", "zero/denormal slices", 64'(out_slices), 64'd0);
      else if (want == '0)
        chk(out_slices == '0, "R9", "underflow slices", 64'(out_slices), 64'd0);
      else if (vec[k][63])
        chk(out_slices[FW-1] == 1'b1, "R5", "top slice sign", 64'(out_slices[FW-1]), 64'd1);
      k++;
    end
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic run_vec();
    logic [10:0] em;
    em = model_exp();
    fork
      send_vec();
      recv_vec(em);
    join
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (4) @(negedge clk);
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R1", "reset state",
        {62'd0, in_ready, out_valid}, 64'd2);
    rst_n = 1'b1;
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R1", "first cycle after reset",
        {62'd0, in_ready, out_valid}, 64'd2);

    // all zeros and denormals: exponent 0 (R3, R6)
    for (int i = 0; i < N; i++) vec[i] = (i % 2) ? 64'h8000_0000_0000_0000 : 64'h0000_0000_0000_0007;
    run_vec();

    // -1.0 as the largest, with mixed signs, a tiny underflow and a zero (R5, R9)
    vec[0] = 64'hBFF0_0000_0000_0000;
    vec[1] = 64'h3FF8_0000_0000_0000;
    vec[2] = 64'h3E00_0000_0000_0001;
    vec[3] = 64'h0000_0000_0000_0000;
    vec[4] = 64'hBFE5_5555_5555_5555;
    vec[5] = 64'h3F90_0000_0000_0000;
    vec[6] = 64'hBFD0_0000_0000_0001;
    vec[7] = 64'h3FEF_FFFF_FFFF_FFFF;
    run_vec();

    // exponent gap at the exact underflow boundary (R9)
    for (int i = 0; i < N; i++) vec[i] = 64'h4000_0000_0000_0000 - (64'(i) << 52);
    vec[N-1] = {1'b1, 11'(1024 - MW), 52'hF_FFFF_FFFF_FFFF};
    vec[N-2] = {1'b0, 11'(1024 - MW + 1), 52'h0};
    run_vec();

    for (int t = 0; t < 40; t++) begin
      int base;
      base = 900 + int'($urandom % 200);
      for (int i = 0; i < N; i++) vec[i] = rnd_elem(base);
      run_vec();
    end

    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL R7 watchdog: actual hung expected completed vectors");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule